// File: doc/BRIEF.md
# Dual Synthesizer Divider and Phase/Frequency Detector

This block is the digital core of two integer-N frequency synthesizers that share one 13 MHz reference. Each loop has three parts. A fixed reference divider turns the shared reference into a comparison tick. A programmable main divider counts edges of that loop's VCO. A phase/frequency detector compares the two ticks and raises an up or a down request toward an analog charge pump.

The RF loop compares at 200 kHz, because its reference divider divides by 65. The IF loop compares at 1 MHz, because its reference divider divides by 13. The RF main divider accepts ratios from 5200 to 8600. The IF main divider typically runs at 200. Ratios are written through a small configuration port into shadow registers, with one register for each band: index 0 is the lower band and index 1 is the upper band. A band-select input chooses which shadow a divider uses. A divider copies its new ratio only at its terminal count, so a write can never disturb a count in progress.

All edges are presented as single-cycle event strobes in one system clock domain. The strobes are `ref_tick`, `rf_vco_tick` and `if_vco_tick`, and they are assumed to be synchronised upstream. Each loop has its own enable. Dropping the enable holds that loop's counters and detector cleared.

Top module: `dual_synth_core`

## Requirements
- R1: With the RF loop enabled, `rf_ref_pulse` goes high for one cycle after every 65th `ref_tick`, counted from enable or reset. It goes high in the cycle after the tick that completes the count.
- R2: With the IF loop enabled, `if_ref_pulse` goes high for one cycle after every 13th `ref_tick`, counted from enable or reset.
- R3: After enable or reset, the first VCO tick of a loop produces a divider pulse in the next cycle. After that, the pulses are separated by exactly N VCO ticks, where N is the ratio loaded at the previous pulse.
- R4: A loaded ratio is clamped to the legal range of its loop: 5200..8600 for RF and 100..1023 for IF. The written field is 14 bits, so values up to 16383 can be written.
- R5: A ratio write never changes the count in progress. The new value is loaded only at the next terminal count. A write in the same cycle as a terminal count applies from the count after that one.
- R6: Each loop holds two shadow ratios, selected by `cfg_band` (0 = lower band, 1 = upper band). The `band_sel` input, sampled at the terminal count, chooses which shadow is loaded.
- R7: `up` goes high one cycle after a reference pulse, and `dn` goes high one cycle after a divider pulse. When both would be high, both clear instead. `up` and `dn` are never high together.
- R8: While a loop's enable is low, its `up`, `dn`, reference pulse and divider pulse outputs are low, and its counters restart when the enable returns.
- R9: During and right after the synchronous active-low reset, all outputs are low and every shadow ratio holds the minimum ratio of its loop.
- R10: A ratio write is accepted while the loop is disabled, and it is used from the loop's first reload after enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per reference edge |
| rf_vco_tick | input | 1 | One-cycle strobe per RF VCO edge |
| if_vco_tick | input | 1 | One-cycle strobe per IF VCO edge |
| rf_en | input | 1 | RF loop power enable |
| if_en | input | 1 | IF loop power enable |
| band_sel | input | 1 | Active band for both loops (0 lower, 1 upper) |
| cfg_we | input | 1 | Ratio write strobe |
| cfg_loop | input | 1 | Target loop (0 RF, 1 IF) |
| cfg_band | input | 1 | Target shadow band |
| cfg_ratio | input | 14 | Ratio value written |
| rf_up | output | 1 | RF charge pump source request |
| rf_dn | output | 1 | RF charge pump sink request |
| if_up | output | 1 | IF charge pump source request |
| if_dn | output | 1 | IF charge pump sink request |
| rf_ref_pulse | output | 1 | RF comparison tick from the reference |
| rf_div_pulse | output | 1 | RF main divider terminal-count pulse |
| if_ref_pulse | output | 1 | IF comparison tick from the reference |
| if_div_pulse | output | 1 | IF main divider terminal-count pulse |

## Verification
If a divider counter is off by one or reloads from the wrong shadow, the fault shows up at the next divider pulse. That pulse lands one or more VCO ticks early or late, up to 8600 ticks after the fault. A reload that happens mid-count because of a write is visible on the very next pulse. A fault in the detector state shows up within one cycle as an `up`/`dn` level that differs from the level computed from the pulses seen in the previous cycle. A loop that stays alive while disabled shows up at once as a nonzero output.

// File: rtl/synth_pkg.sv
// Package: shared defaults and encodings for the dual synthesizer core.
// Assumes all users agree on the band and loop index encodings given here.
package synth_pkg;
    localparam int DEF_RATIO_W   = 14;
    localparam int DEF_RF_REF    = 65;
    localparam int DEF_IF_REF    = 13;
    localparam int DEF_RF_N_MIN  = 5200;
    localparam int DEF_RF_N_MAX  = 8600;
    localparam int DEF_IF_N_MIN  = 100;
    localparam int DEF_IF_N_MAX  = 1023;
    localparam int NUM_LOOPS     = 2;

    typedef enum logic { BAND_LOW = 1'b0, BAND_HIGH = 1'b1 } band_e;
    typedef enum logic { LOOP_RF = 1'b0, LOOP_IF = 1'b1 } loop_e;
endpackage

// File: rtl/syn_ref_div.sv
// Fixed-ratio reference divider: counts reference strobes and emits a one-cycle
// comparison pulse after every RATIO strobes. Assumes RATIO >= 2.
// Cleared by reset or by the loop enable going low.
module syn_ref_div #(
    parameter int RATIO = 65
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    output logic pulse
);
    localparam int CW = $clog2(RATIO);
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] cnt;

    // Count reference strobes and flag the one that completes the ratio.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= tick && (cnt == LAST);
            if (tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    AST_REF_GAP: assert property (@(posedge clk) disable iff (!rst_n) pulse |=> !pulse); // R1
    AST_REF_OFF: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !pulse); // R8
endmodule

// File: rtl/syn_main_div.sv
// Programmable main divider with double-buffered ratios. Two shadow ratios
// (one per band) are written at any time. The down-counter reads the shadow
// chosen by band_sel only at terminal count, after clamping it to [N_MIN, N_MAX].
// Assumes N_MIN >= 2 and N_MAX < 2**W.
module syn_main_div #(
    parameter int W     = 14,
    parameter int N_MIN = 5200,
    parameter int N_MAX = 8600
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic         band_sel,
    input  logic         wr_en,
    input  logic         wr_band,
    input  logic [W-1:0] wr_ratio,
    output logic         pulse
);
    localparam logic [W-1:0] LO = W'(N_MIN);
    localparam logic [W-1:0] HI = W'(N_MAX);

    logic [W-1:0] shadow [2];
    logic [W-1:0] cnt;
    logic [W-1:0] sel_ratio;

    // Limit a requested ratio to the legal range of this loop.
    function automatic logic [W-1:0] clamp_ratio(input logic [W-1:0] v);
        if (v < LO)      return LO;
        else if (v > HI) return HI;
        else             return v;
    endfunction

    // Pick and clamp the shadow ratio for the active band.
    always_comb sel_ratio = clamp_ratio(shadow[band_sel]);

    // Shadow ratio storage: written freely, reset only by the chip reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow[0] <= LO;
            shadow[1] <= LO;
        end else if (wr_en) begin
            shadow[wr_band] <= wr_ratio;
        end
    end

    // Down-counter: reloads ratio-1 and pulses on the tick that finds zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= tick && (cnt == '0);
            if (tick) cnt <= (cnt == '0) ? sel_ratio - 1'b1 : cnt - 1'b1;
        end
    end

    AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt < HI); // R4
    AST_DIV_TICK:  assert property (@(posedge clk) disable iff (!rst_n) pulse |-> $past(tick)); // R3
    AST_DIV_GAP:   assert property (@(posedge clk) disable iff (!rst_n) pulse |=> !pulse); // R3
    AST_DIV_OFF:   assert property (@(posedge clk) disable iff (!rst_n) !en |=> !pulse); // R8
endmodule

// File: rtl/syn_pfd.sv
// Phase/frequency detector: a registered up/down pair. A reference pulse sets
// up, a divider pulse sets dn, and a state that would hold both clears both.
// Assumes both input pulses are synchronous one-cycle strobes.
module syn_pfd (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ref_p,
    input  logic div_p,
    output logic up,
    output logic dn
);
    logic up_nx, dn_nx;

    // Set from the pulses, then collapse the both-set case to idle.
    always_comb begin
        up_nx = up | ref_p;
        dn_nx = dn | div_p;
        if (up_nx && dn_nx) begin
            up_nx = 1'b0;
            dn_nx = 1'b0;
        end
    end

    // Register the detector state, held clear while off.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            up <= 1'b0;
            dn <= 1'b0;
        end else begin
            up <= up_nx;
            dn <= dn_nx;
        end
    end

    AST_PFD_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(up && dn)); // R7
    AST_PFD_SET:  assert property (@(posedge clk) disable iff (!rst_n) (en && ref_p && !div_p && !dn) |=> up); // R7
    AST_PFD_OFF:  assert property (@(posedge clk) disable iff (!rst_n) !en |=> (!up && !dn)); // R8
endmodule

// File: rtl/dual_synth_core.sv
// Top: two synthesizer loops (RF, IF) sharing one reference strobe. Each loop
// has a fixed reference divider, a programmable main divider and a PFD, all
// built by one generate loop. Assumes every input strobe is already
// synchronous to clk and lasts one cycle.
module dual_synth_core #(
    parameter int RATIO_W  = synth_pkg::DEF_RATIO_W,
    parameter int RF_REF   = synth_pkg::DEF_RF_REF,
    parameter int IF_REF   = synth_pkg::DEF_IF_REF,
    parameter int RF_N_MIN = synth_pkg::DEF_RF_N_MIN,
    parameter int RF_N_MAX = synth_pkg::DEF_RF_N_MAX,
    parameter int IF_N_MIN = synth_pkg::DEF_IF_N_MIN,
    parameter int IF_N_MAX = synth_pkg::DEF_IF_N_MAX
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_tick,
    input  logic               rf_vco_tick,
    input  logic               if_vco_tick,
    input  logic               rf_en,
    input  logic               if_en,
    input  logic               band_sel,
    input  logic               cfg_we,
    input  logic               cfg_loop,
    input  logic               cfg_band,
    input  logic [RATIO_W-1:0] cfg_ratio,
    output logic               rf_up,
    output logic               rf_dn,
    output logic               if_up,
    output logic               if_dn,
    output logic               rf_ref_pulse,
    output logic               rf_div_pulse,
    output logic               if_ref_pulse,
    output logic               if_div_pulse
);
    import synth_pkg::*;

    logic [NUM_LOOPS-1:0] en_v, vco_v, refp_v, divp_v, up_v, dn_v;

    assign en_v  = {if_en, rf_en};
    assign vco_v = {if_vco_tick, rf_vco_tick};

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
        localparam int REF_R = (g == int'(LOOP_RF)) ? RF_REF   : IF_REF;
        localparam int N_LO  = (g == int'(LOOP_RF)) ? RF_N_MIN : IF_N_MIN;
        localparam int N_HI  = (g == int'(LOOP_RF)) ? RF_N_MAX : IF_N_MAX;

        logic wr_here;
        assign wr_here = cfg_we && (cfg_loop == 1'(g));

        syn_ref_div #(.RATIO(REF_R)) ref_div_i (
            .clk(clk), .rst_n(rst_n), .en(en_v[g]), .tick(ref_tick), .pulse(refp_v[g])
        );

        syn_main_div #(.W(RATIO_W), .N_MIN(N_LO), .N_MAX(N_HI)) main_div_i (
            .clk(clk), .rst_n(rst_n), .en(en_v[g]), .tick(vco_v[g]),
            .band_sel(band_sel), .wr_en(wr_here), .wr_band(cfg_band),
            .wr_ratio(cfg_ratio), .pulse(divp_v[g])
        );

        syn_pfd pfd_i (
            .clk(clk), .rst_n(rst_n), .en(en_v[g]),
            .ref_p(refp_v[g]), .div_p(divp_v[g]), .up(up_v[g]), .dn(dn_v[g])
        );
    end

    assign rf_up        = up_v[0];
    assign rf_dn        = dn_v[0];
    assign if_up        = up_v[1];
    assign if_dn        = dn_v[1];
    assign rf_ref_pulse = refp_v[0];
    assign if_ref_pulse = refp_v[1];
    assign rf_div_pulse = divp_v[0];
    assign if_div_pulse = divp_v[1];

    AST_TOP_RST: assert property (@(posedge clk) !rst_n |=> (up_v == '0 && dn_v == '0 && divp_v == '0)); // R9
endmodule

// File: tb/dual_synth_core_tb_top.sv
`timescale 1ns/1ps
module dual_synth_core_tb_top;
    localparam int REF_R [2] = '{65, 13};
    localparam int N_LO  [2] = '{5200, 100};
    localparam int N_HI  [2] = '{8600, 1023};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_tick = 1'b0, rf_vco_tick = 1'b0, if_vco_tick = 1'b0;
    logic rf_en = 1'b0, if_en = 1'b0, band_sel = 1'b0;
    logic cfg_we = 1'b0, cfg_loop = 1'b0, cfg_band = 1'b0;
    logic [13:0] cfg_ratio = '0;
    logic rf_up, rf_dn, if_up, if_dn;
    logic rf_ref_pulse, rf_div_pulse, if_ref_pulse, if_div_pulse;

    always #2 clk = ~clk;

    dual_synth_core dut_i (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .rf_vco_tick(rf_vco_tick),
        .if_vco_tick(if_vco_tick), .rf_en(rf_en), .if_en(if_en), .band_sel(band_sel),
        .cfg_we(cfg_we), .cfg_loop(cfg_loop), .cfg_band(cfg_band), .cfg_ratio(cfg_ratio),
        .rf_up(rf_up), .rf_dn(rf_dn), .if_up(if_up), .if_dn(if_dn),
        .rf_ref_pulse(rf_ref_pulse), .rf_div_pulse(rf_div_pulse),
        .if_ref_pulse(if_ref_pulse), .if_div_pulse(if_div_pulse)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    int cyc = 0;

    // Bench model state
    int ref_cnt [2], div_cnt [2], div_exp [2], last_gap [2], pulses [2];
    int shadow_m [2][2];
    bit up_m [2], dn_m [2], prev_refp [2], prev_divp [2];
    int tick_mode [2];   // 0 off, 1 every cycle, 2 random

    function automatic int bclamp(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic model_clear(input int g);
        ref_cnt[g] = 0; div_cnt[g] = 0; div_exp[g] = 1;
        up_m[g] = 0; dn_m[g] = 0; prev_refp[g] = 0; prev_divp[g] = 0;
    endtask

    // One cycle: wait for the falling edge, check outputs against the model
    // using the inputs that were applied at the rising edge, update the model.
    task automatic step();
        logic [1:0] en_a, vco_a, up_o, dn_o, rp_o, dp_o;
        @(negedge clk);
        en_a = {if_en, rf_en};
        vco_a = {if_vco_tick, rf_vco_tick};
        up_o = {if_up, rf_up}; dn_o = {if_dn, rf_dn};
        rp_o = {if_ref_pulse, rf_ref_pulse}; dp_o = {if_div_pulse, rf_div_pulse};
        for (int g = 0; g < 2; g++) begin
            if (!rst_n) begin
                chk({up_o[g], dn_o[g], rp_o[g], dp_o[g]}, 0, "R9 outputs in reset");
                model_clear(g);
                for (int b = 0; b < 2; b++) shadow_m[g][b] = N_LO[g];
            end else if (!en_a[g]) begin
                chk({up_o[g], dn_o[g], rp_o[g], dp_o[g]}, 0, "R8 outputs while off");
                model_clear(g);
            end else begin
                bit nu, nd;
                nu = up_m[g] | prev_refp[g];
                nd = dn_m[g] | prev_divp[g];
                if (nu && nd) begin nu = 0; nd = 0; end
                chk(up_o[g], nu, "R7 up level");
                chk(dn_o[g], nd, "R7 dn level");
                up_m[g] = nu; dn_m[g] = nd;
                if (ref_tick) ref_cnt[g]++;
                if (rp_o[g]) begin
                    chk(ref_cnt[g], REF_R[g], g == 0 ? "R1 RF ref spacing" : "R2 IF ref spacing");
                    ref_cnt[g] = 0;
                end else if (ref_cnt[g] >= REF_R[g]) begin
                    chk(0, 1, g == 0 ? "R1 RF ref pulse missing" : "R2 IF ref pulse missing");
                    ref_cnt[g] = 0;
                end
                if (vco_a[g]) div_cnt[g]++;
                if (dp_o[g]) begin
                    chk(div_cnt[g], div_exp[g], "R3 R5 divider spacing");
                    last_gap[g] = div_cnt[g];
                    pulses[g]++;
                    div_exp[g] = bclamp(shadow_m[g][band_sel], N_LO[g], N_HI[g]);
                    div_cnt[g] = 0;
                end else if (div_cnt[g] >= div_exp[g]) begin
                    chk(0, 1, "R3 divider pulse missing");
                    div_cnt[g] = 0;
                end
                prev_refp[g] = rp_o[g]; prev_divp[g] = dp_o[g];
            end
        end
        if (rst_n && cfg_we) shadow_m[cfg_loop][cfg_band] = cfg_ratio;
        // drive next-cycle strobes
        ref_tick = ($urandom % 4) != 0;
        rf_vco_tick = tick_mode[0] == 1 ? 1'b1 : (tick_mode[0] == 2 ? (($urandom % 8) != 0) : 1'b0);
        if_vco_tick = tick_mode[1] == 1 ? 1'b1 : (tick_mode[1] == 2 ? (($urandom % 8) != 0) : 1'b0);
        cfg_we = 1'b0;
    endtask

    task automatic write_ratio(input int loop, input int band, input int val);
        cfg_we = 1'b1; cfg_loop = loop[0]; cfg_band = band[0]; cfg_ratio = val[13:0];
        step();
    endtask

    task automatic wait_pulses(input int g, input int n);
        int target = pulses[g] + n;
        for (int k = 0; k < 30000 && pulses[g] < target; k++) step();
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int g = 0; g < 2; g++) begin
            model_clear(g); last_gap[g] = 0; pulses[g] = 0; tick_mode[g] = 2;
            for (int b = 0; b < 2; b++) shadow_m[g][b] = N_LO[g];
        end
        // Reset state (R9)
        for (int k = 0; k < 6; k++) step();
        rst_n = 1'b1; rf_en = 1'b1; if_en = 1'b1;

        // Constrained random phase: R1 R2 R3 R5 R6 R7 R8
        for (int k = 0; k < 50000; k++) begin
            step();
            if (($urandom % 2500) == 0) begin
                int lp = $urandom % 2;
                int v = (lp == 0) ? 5150 + ($urandom % 3500) : 90 + ($urandom % 250);
                cfg_we = 1'b1; cfg_loop = lp[0]; cfg_band = 1'($urandom % 2); cfg_ratio = v[13:0];
            end
            if (($urandom % 4000) == 0) band_sel = ~band_sel;
            if (($urandom % 6000) == 0) rf_en = ~rf_en;
            if (($urandom % 3000) == 0) if_en = ~if_en;
        end

        // R10 and R4 upper clamp: write while RF is off, then enable.
        band_sel = 1'b0; if_en = 1'b1; tick_mode[0] = 1; tick_mode[1] = 1;
        rf_en = 1'b0; step(); step();
        write_ratio(0, 0, 16383);
        rf_en = 1'b1;
        wait_pulses(0, 2);
        chk(last_gap[0], 8600, "R4 R10 clamped high ratio after enable");

        // R5 then R4 lower clamp: write mid-count, old ratio finishes first.
        for (int k = 0; k < 100; k++) step();
        write_ratio(0, 0, 10);
        wait_pulses(0, 1);
        chk(last_gap[0], 8600, "R5 count in progress kept old ratio");
        wait_pulses(0, 1);
        chk(last_gap[0], 5200, "R4 clamped low ratio");

        // R6: upper band shadow selected by band_sel.
        write_ratio(0, 1, 6000);
        write_ratio(1, 1, 2000);
        write_ratio(1, 0, 5);
        band_sel = 1'b1;
        wait_pulses(0, 2);
        chk(last_gap[0], 6000, "R6 upper band ratio");
        wait_pulses(1, 2);
        chk(last_gap[1], 1023, "R6 R4 IF upper band clamped");
        band_sel = 1'b0;
        wait_pulses(1, 2);
        chk(last_gap[1], 100, "R6 R4 IF lower band clamped");

        // R7: IF VCO silent, reference running, so up must latch high.
        tick_mode[1] = 0;
        for (int k = 0; k < 200; k++) step();
        chk(if_up, 1, "R7 up held with no divider edges");
        chk(if_dn, 0, "R7 dn low with no divider edges");

        // R8: powering the IF loop off clears its requests.
        if_en = 1'b0; step(); step();
        chk(if_up, 0, "R8 up cleared when off");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule